// File: doc/BRIEF.md
# Bit-Pipelined Line Broadcast Network

This block copies one 16-bit word from a single element of a line of `N_PE` processing elements into every other element of that line. The only data path between elements is one 1-bit register per element. Each register feeds only its two immediate neighbours, so wire length does not grow with the line length. When the start strobe arrives, the chosen source element begins shifting its word out, least significant bit first. Every other element relays each bit one clock after it receives it, so a bit moves one element per cycle.

Each element decides for itself, from its own index and the source index, whether it is the source or a destination. A destination also works out its distance to the source and from that the cycle in which its 16-bit stream begins. Elements with an index below the source take bits from their higher-index neighbour. Elements above the source take bits from their lower-index neighbour. Once an element holds the whole word it raises its own ready flag. A controller can combine these flags to see when the broadcast is complete.

The source is either given by an explicit index or, in diagonal mode, is the element whose index equals the line's own number. The word sent is either the source's accumulator-high input or its PS input, chosen by a select bit.

Top module: `bcast_line`

## Requirements
- R1: After reset, every `word_o` slice is 0 and every `ready_o` bit is 0.
- R2: With `diag_i`=0, the element whose index equals `src_idx_i` at the start edge is the source.
- R3: With `diag_i`=1, the source is the element whose index equals `line_idx_i`, and `src_idx_i` has no effect.
- R4: The word sent is the source's `acc_hi_i` slice when `sel_i`=0 and its `ps_i` slice when `sel_i`=1, both sampled at the start edge.
- R5: The source's `word_o` equals the sent word from the clock edge that samples `start_i` onward. Its `ready_o` rises after the 15th edge following that start edge.
- R6: A destination at distance d from the source takes in one bit per edge, LSB first, at edges d through d+15 after the start edge (the start edge is edge 0). Its `word_o` shifts each new bit in at bit 15 and moves the earlier bits toward bit 0. The slice is cleared at the start edge.
- R7: A destination at distance d raises `ready_o` after edge d+15. The last element of the line is therefore ready (N_PE-2)+16 cycles after the start edge.
- R8: The start edge clears every `ready_o` bit. Once set, a ready bit and its `word_o` slice stay unchanged until the next start.
- R9: Changing `acc_hi_i`, `ps_i`, `sel_i`, `src_idx_i`, `diag_i` or `line_idx_i` after the start edge has no effect on the broadcast in progress.
- R10: Elements on both sides of the source receive the word, whatever the source position, including the two ends of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| diag_i | input | 1 | 1: source is the element at index `line_idx_i` |
| sel_i | input | 1 | Word select: 0 accumulator high word, 1 PS |
| src_idx_i | input | IDX_W | Source element index when `diag_i`=0 |
| line_idx_i | input | IDX_W | Number of this line, used in diagonal mode |
| acc_hi_i | input | N_PE*WORD_W | Accumulator high word per element, element i at bits [i*WORD_W +: WORD_W] |
| ps_i | input | N_PE*WORD_W | PS word per element, same packing |
| word_o | output | N_PE*WORD_W | Received (or, for the source, held) word per element |
| ready_o | output | N_PE | Per-element completion flag |

## Verification
The hardest case to reach from the ports is proving that a destination's capture window is tied to its own distance, and that none of its bits is taken one hop early or late. The bench therefore compares every element's partially filled word on every cycle, not only the final word, for every source position and in both modes. The inputs are scrambled right after each start edge. Any sampling after the start edge then shows up as a miscompare.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
  typedef enum logic {
    SEL_ACC_HI = 1'b0,
    SEL_PS     = 1'b1
  } word_sel_e;
endpackage

// File: rtl/bcast_src_sel.sv
module bcast_src_sel #(
  parameter int IDX_W = 3
) (
  input  logic             diag_i,
  input  logic [IDX_W-1:0] src_idx_i,
  input  logic [IDX_W-1:0] line_idx_i,
  output logic [IDX_W-1:0] src_o
);
  // diagonal: the element whose index equals the line number sends
  assign src_o = diag_i ? line_idx_i : src_idx_i;
endmodule

// File: rtl/bcast_node_dec.sv
module bcast_node_dec #(
  parameter int IDX_W    = 3,
  parameter int NODE_IDX = 0
) (
  input  logic [IDX_W-1:0] src_i,
  output logic             is_src_o,
  output logic             from_east_o,
  output logic [IDX_W-1:0] dist_o
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(NODE_IDX);

  always_comb begin
    is_src_o    = (src_i == MY_IDX);
    from_east_o = (MY_IDX < src_i);
    dist_o      = from_east_o ? (src_i - MY_IDX) : (MY_IDX - src_i);
  end
endmodule

// File: rtl/bcast_node.sv
module bcast_node
  import bcast_pkg::*;
#(
  parameter int N_PE     = 8,
  parameter int WORD_W   = 16,
  parameter int NODE_IDX = 0,
  localparam int IDX_W   = (N_PE > 1) ? $clog2(N_PE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  src_i,
  input  word_sel_e         sel_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] ps_i,
  input  logic              west_r_i,
  input  logic              east_r_i,
  output logic              r_o,
  output logic [WORD_W-1:0] word_o,
  output logic              ready_o
);
  localparam int CNT_W = $clog2(N_PE + WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_OFS = CNT_W'(WORD_W - 1);

  logic             dec_src, dec_east;
  logic [IDX_W-1:0] dec_dist;

  bcast_node_dec #(.IDX_W(IDX_W), .NODE_IDX(NODE_IDX)) u_dec (
    .src_i       (src_i),
    .is_src_o    (dec_src),
    .from_east_o (dec_east),
    .dist_o      (dec_dist)
  );

  logic [WORD_W-1:0] load_word;
  assign load_word = (sel_i == SEL_PS) ? ps_i : acc_i;

  logic              is_src_q, from_east_q, run_q, r_q, rdy_q;
  logic [CNT_W-1:0]  dist_q, cnt_q;
  logic [WORD_W-1:0] tx_q, rx_q;
  logic              link_bit;

  assign link_bit = from_east_q ? east_r_i : west_r_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_src_q    <= 1'b0;
      from_east_q <= 1'b0;
      run_q       <= 1'b0;
      r_q         <= 1'b0;
      rdy_q       <= 1'b0;
      dist_q      <= '0;
      cnt_q       <= '0;
      tx_q        <= '0;
      rx_q        <= '0;
    end else if (start_i) begin
      is_src_q    <= dec_src;
      from_east_q <= dec_east;
      dist_q      <= CNT_W'(dec_dist);
      cnt_q       <= CNT_W'(1);
      run_q       <= 1'b1;
      rdy_q       <= 1'b0;
      if (dec_src) begin
        r_q  <= load_word[0];
        tx_q <= load_word >> 1;
        rx_q <= load_word;
      end else begin
        r_q  <= 1'b0;
        tx_q <= '0;
        rx_q <= '0;
      end
    end else if (run_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (is_src_q) begin
        r_q  <= tx_q[0];
        tx_q <= tx_q >> 1;
      end else if (cnt_q >= dist_q) begin
        // capture window: edges dist .. dist+WORD_W-1
        r_q  <= link_bit;
        rx_q <= {link_bit, rx_q[WORD_W-1:1]};
      end
      if (cnt_q == dist_q + LAST_OFS) begin
        rdy_q <= 1'b1;
        run_q <= 1'b0;
      end
    end
  end

  assign r_o     = r_q;
  assign word_o  = rx_q;
  assign ready_o = rdy_q;
endmodule

// File: rtl/bcast_line.sv
module bcast_line
  import bcast_pkg::*;
#(
  parameter int N_PE   = 8,
  parameter int WORD_W = 16,
  localparam int IDX_W = (N_PE > 1) ? $clog2(N_PE) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     diag_i,
  input  logic                     sel_i,
  input  logic [IDX_W-1:0]         src_idx_i,
  input  logic [IDX_W-1:0]         line_idx_i,
  input  logic [N_PE*WORD_W-1:0]   acc_hi_i,
  input  logic [N_PE*WORD_W-1:0]   ps_i,
  output logic [N_PE*WORD_W-1:0]   word_o,
  output logic [N_PE-1:0]          ready_o
);
  logic [IDX_W-1:0] src_eff;
  logic [N_PE-1:0]  r_bus;
  word_sel_e        sel_e;

  assign sel_e = word_sel_e'(sel_i);

  bcast_src_sel #(.IDX_W(IDX_W)) u_src_sel (
    .diag_i     (diag_i),
    .src_idx_i  (src_idx_i),
    .line_idx_i (line_idx_i),
    .src_o      (src_eff)
  );

  for (genvar g = 0; g < N_PE; g++) begin : g_node
    logic west_r, east_r;
    if (g == 0) begin : g_wedge
      assign west_r = 1'b0;
    end else begin : g_win
      assign west_r = r_bus[g-1];
    end
    if (g == N_PE - 1) begin : g_eedge
      assign east_r = 1'b0;
    end else begin : g_ein
      assign east_r = r_bus[g+1];
    end

    bcast_node #(.N_PE(N_PE), .WORD_W(WORD_W), .NODE_IDX(g)) u_node (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .src_i    (src_eff),
      .sel_i    (sel_e),
      .acc_i    (acc_hi_i[g*WORD_W +: WORD_W]),
      .ps_i     (ps_i[g*WORD_W +: WORD_W]),
      .west_r_i (west_r),
      .east_r_i (east_r),
      .r_o      (r_bus[g]),
      .word_o   (word_o[g*WORD_W +: WORD_W]),
      .ready_o  (ready_o[g])
    );
  end
endmodule

// File: rtl/bcast_line_chk.sv
module bcast_line_chk #(
  parameter int N_PE   = 8,
  parameter int WORD_W = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic [N_PE*WORD_W-1:0] word_o,
  input logic [N_PE-1:0]        ready_o
);
  localparam int CYC_W = $clog2(N_PE + WORD_W + 2);
  localparam logic [CYC_W-1:0] CYC_MAX = CYC_W'(N_PE + WORD_W);
  localparam logic [CYC_W-1:0] CYC_ALL = CYC_W'(N_PE + WORD_W - 1);
  localparam logic [CYC_W-1:0] CYC_MIN = CYC_W'(WORD_W);

  logic [CYC_W-1:0] cyc_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      cyc_q   <= CYC_W'(1);
      armed_q <= 1'b1;
    end else if (armed_q && cyc_q != CYC_MAX) begin
      cyc_q <= cyc_q + CYC_W'(1);
    end
  end

  // R8
  ready_clear_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ready_o == '0));

  // R8
  ready_falls_only_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(ready_o) & ~ready_o)) |-> $past(start_i));

  // R5
  no_early_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ready_o) |-> (armed_q && cyc_q >= CYC_MIN));

  // R7
  all_ready_by_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cyc_q == CYC_ALL) |-> (&ready_o));

  for (genvar g = 0; g < N_PE; g++) begin : g_stab
    // R8
    word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o[g] && !start_i) |=> $stable(word_o[g*WORD_W +: WORD_W]));
  end
endmodule

bind bcast_line bcast_line_chk #(.N_PE(N_PE), .WORD_W(WORD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .word_o  (word_o),
  .ready_o (ready_o)
);

// File: tb/bcast_line_test.sv
module bcast_line_test;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int IW = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic           diag_i = 1'b0;
  logic           sel_i = 1'b0;
  logic [IW-1:0]  src_idx_i = '0;
  logic [IW-1:0]  line_idx_i = '0;
  logic [N*W-1:0] acc_hi_i = '0;
  logic [N*W-1:0] ps_i = '0;
  logic [N*W-1:0] word_o;
  logic [N-1:0]   ready_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // model state
  int         m_e = -1;
  int         m_src = 0;
  logic [W-1:0] m_word = '0;
  string      ctx = "R1";

  always #4 clk_i = ~clk_i;

  bcast_line #(.N_PE(N), .WORD_W(W)) uut (.*);

  function automatic logic [W-1:0] gen_word(int i, int run, int salt);
    logic [W-1:0] v;
    v = W'(i * 16'h1357 + run * 16'h2b3d + salt * 16'h4e1f + 16'h00a5);
    return v ^ W'(run << 3);
  endfunction

  function automatic logic [W-1:0] part_word(logic [W-1:0] w, int k);
    if (k <= 0) return '0;
    if (k >= W) return w;
    return w << (W - k);
  endfunction

  task automatic fill_inputs(int run, int salt);
    for (int i = 0; i < N; i++) begin
      acc_hi_i[i*W +: W] = gen_word(i, run, salt);
      ps_i[i*W +: W]     = ~gen_word(i, run, salt + 7);
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < N; i++) begin
      int d, k;
      logic [W-1:0] exp_w;
      logic exp_r;
      if (m_e < 0) begin
        exp_w = '0; exp_r = 1'b0;
      end else begin
        d = (i > m_src) ? i - m_src : m_src - i;
        exp_r = (m_e >= d + W - 1);
        if (d == 0) exp_w = m_word;
        else begin
          k = m_e - d + 1;
          exp_w = part_word(m_word, k);
        end
      end
      vectors++;
      if (ready_o[i] !== exp_r) begin
        miscompares++;
        $display("FAIL %s R7 R8 elem %0d e=%0d ready act=%b exp=%b", ctx, i, m_e, ready_o[i], exp_r);
      end
      vectors++;
      if (word_o[i*W +: W] !== exp_w) begin
        miscompares++;
        $display("FAIL %s %s elem %0d e=%0d word act=%h exp=%h", ctx,
                 (i == m_src) ? "R5" : "R6", i, m_e, word_o[i*W +: W], exp_w);
      end
    end
  endtask

  // one broadcast, start applied at the next posedge, run to full completion
  task automatic run_bcast(int run, bit diag, bit sel, int src, int line, bit scramble);
    int s_eff;
    fill_inputs(run, 0);
    diag_i     = diag;
    sel_i      = sel;
    src_idx_i  = IW'(src);
    line_idx_i = IW'(line);
    start_i    = 1'b1;
    s_eff      = diag ? line : src;
    @(negedge clk_i);
    start_i = 1'b0;
    m_e   = 0;
    m_src = s_eff;
    m_word = sel ? ps_i[s_eff*W +: W] : acc_hi_i[s_eff*W +: W];
    check_all();
    if (scramble) begin
      fill_inputs(run, 3);
      diag_i = ~diag; sel_i = ~sel;
      src_idx_i = ~IW'(src); line_idx_i = ~IW'(line);
    end
    for (int c = 1; c < N + W + 2; c++) begin
      @(negedge clk_i);
      m_e++;
      check_all();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    ctx = "R1";
    check_all();
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all();

    // explicit index, every source, both words, both sides
    for (int s = 0; s < N; s++) begin
      ctx = "R2 R4 R10";
      run_bcast(s, 1'b0, 1'b0, s, (s + 3) % N, 1'b0);
      run_bcast(s + 20, 1'b0, 1'b1, s, (s + 5) % N, 1'b0);
    end
    // diagonal mode, src index deliberately different
    for (int l = 0; l < N; l++) begin
      ctx = "R3 R4";
      run_bcast(l + 40, 1'b1, l[0], (l + 1) % N, l, 1'b0);
    end
    // inputs changed right after start
    for (int s = 0; s < N; s += 3) begin
      ctx = "R9";
      run_bcast(s + 60, 1'b0, 1'b1, s, 0, 1'b1);
      run_bcast(s + 70, 1'b1, 1'b0, 0, s, 1'b1);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule